// File: doc/BRIEF.md
# Versioned Context Transfer Unit

One instance of this unit sits beside each column of a reconfigurable fabric. It moves task contexts between a small per-column context store and the column's hidden scan plane. A supervisor drives it through four word-wide registers: it writes a slot index, a task identifier and an expected version, and then writes a command code that either saves the hidden plane into a slot or restores a slot into the hidden plane. Each transfer shifts exactly `N` bits over a single-bit scan path, one bit per clock and least significant bit first.

Every save stamps the slot with a fresh version taken from a running counter. The supervisor keeps its own count, so it always knows which version is current. A restore goes ahead only if the slot is valid, holds the requested task and carries exactly the expected version. A stale or mismatched copy is refused without touching the scan plane. After each save the slot is marked dirty and a write-through request is raised. The request carries the slot, task, version and context bits so that the central repository can take a copy. It stays up until the repository acknowledges it.

The controller has three states: `ST_IDLE`, `ST_SAVE` and `ST_LOAD`. The transitions are named as follows. *start_save* goes from `ST_IDLE` to `ST_SAVE` on an accepted save. *start_load* goes from `ST_IDLE` to `ST_LOAD` on a restore that passes the version check. *refuse* keeps `ST_IDLE` on a failed check or an out-of-range slot. *shift* keeps the current transfer state while the bit count is below `N-1`. *finish* returns from either transfer state to `ST_IDLE` on the last bit.

Top module: `ctxv_unit`

## Requirements
- R1: After reset, every slot is invalid and not dirty, the version counter is 0, the status word reads 0, `scan_en` is low and `wt_req` is low.
- R2: Register addresses are fixed: 0 is the command register on write and the status register on read, 1 is the slot index, 2 is the task ID and 3 is the expected version. Command code 1 is a save and command code 2 is a restore, taken from data bits [1:0]. Codes 0 and 3 are ignored and leave the status unchanged.
- R3: A save increments the version counter and stamps the new value into the slot. The first save after reset is therefore version 1. The counter is shown in status bits [15:8].
- R4: A save shifts `scan_in` into the slot over `N` cycles, LSB first, starting the cycle after the command. The slot becomes valid and holds the task ID that was latched at the command.
- R5: A restore whose slot is valid, holds a matching task ID and has a version equal to the expected-version register drives the slot's bits on `scan_out` over `N` cycles, LSB first, starting the cycle after the command.
- R6: A restore that fails the check sets the error flag (status bit 2) and never raises `scan_en`.
- R7: While a transfer runs, status bit 0 is high and `scan_en` is high for exactly `N` consecutive cycles. Status bit 3 (done) is set when the transfer ends.
- R8: A valid command written while busy sets the reject flag (status bit 1) and has no other effect.
- R9: After a save, `wt_req` rises and presents the slot, task, version and data. It holds until `wt_ack` is high on a clock edge. The slot's dirty bit (status bit 4+slot) stays set until then.
- R10: When several slots are dirty and no request is held, the lowest-numbered slot is presented next. A presented slot is not replaced before it is acknowledged.
- R11: If a save commits into the presented slot on the same edge as its acknowledge, the slot stays dirty and is presented again with the new version.
- R12: A command naming slot index 3 or more sets the error flag and starts no transfer.
- R13: An accepted or refused command clears the reject and done flags and rewrites the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| scan_en | output | 1 | Hidden-plane shift enable |
| scan_out | output | 1 | Bit shifted into the hidden plane on restore |
| scan_in | input | 1 | Bit shifted out of the hidden plane on save |
| wt_req | output | 1 | Write-through request |
| wt_ack | input | 1 | Write-through acknowledge |
| wt_slot | output | 2 | Slot being written through |
| wt_task | output | 4 | Task ID of that slot |
| wt_ver | output | 8 | Version of that slot |
| wt_data | output | 16 | Context bits of that slot |

## Verification
The risky overlap is a save that commits into the slot currently offered for write-through, on the same edge that the repository acknowledges it. The bench provokes this by raising `wt_ack` during the last shift cycle of a second save into the presented slot. It then expects the dirty bit to survive and the request to return one gap cycle later with the new version and data. A second overlap is a command that lands on the final busy cycle, which must still be rejected. In both cases a behavioural model, updated on every edge, judges each port on every clock alongside the directed checks.

// File: rtl/ctxv_pkg.sv
package ctxv_pkg;
    localparam int REG_W = 16;
    localparam int VER_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SAVE = 2'd1,
        ST_LOAD = 2'd2
    } xfer_st_e;

    localparam logic [1:0] A_CMD  = 2'd0;
    localparam logic [1:0] A_SLOT = 2'd1;
    localparam logic [1:0] A_TASK = 2'd2;
    localparam logic [1:0] A_EXPV = 2'd3;

    localparam logic [1:0] OP_SAVE = 2'b01;
    localparam logic [1:0] OP_LOAD = 2'b10;
endpackage

// File: rtl/ctxv_regs.sv
module ctxv_regs
    import ctxv_pkg::*;
#(
    parameter int SW     = 2,
    parameter int TASK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic [REG_W-1:0]  status,
    output logic [REG_W-1:0]  reg_rdata,
    output logic [SW-1:0]     slot_idx,
    output logic [TASK_W-1:0] task_id,
    output logic [VER_W-1:0]  exp_ver,
    output logic              cmd_wr,
    output logic [1:0]        cmd_op
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_idx <= '0;
            task_id  <= '0;
            exp_ver  <= '0;
        end else if (reg_we) begin
            unique case (reg_addr)
                A_SLOT:  slot_idx <= reg_wdata[SW-1:0];
                A_TASK:  task_id  <= reg_wdata[TASK_W-1:0];
                A_EXPV:  exp_ver  <= reg_wdata[VER_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        cmd_wr = reg_we && (reg_addr == A_CMD);
        cmd_op = reg_wdata[1:0];
        unique case (reg_addr)
            A_CMD:   reg_rdata = status;
            A_SLOT:  reg_rdata = REG_W'(slot_idx);
            A_TASK:  reg_rdata = REG_W'(task_id);
            default: reg_rdata = REG_W'(exp_ver);
        endcase
    end
endmodule

// File: rtl/ctxv_store.sv
module ctxv_store
    import ctxv_pkg::*;
#(
    parameter int NSLOT  = 3,
    parameter int SW     = 2,
    parameter int TASK_W = 4,
    parameter int N      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              c_we,
    input  logic [SW-1:0]     c_slot,
    input  logic [TASK_W-1:0] c_task,
    input  logic [N-1:0]      c_data,
    input  logic [SW-1:0]     lk_idx,
    output logic              lk_valid,
    output logic [TASK_W-1:0] lk_task,
    output logic [VER_W-1:0]  lk_ver,
    output logic [N-1:0]      lk_data,
    input  logic              wt_ack,
    output logic              wt_req,
    output logic [SW-1:0]     wt_slot,
    output logic [TASK_W-1:0] wt_task,
    output logic [VER_W-1:0]  wt_ver,
    output logic [N-1:0]      wt_data,
    output logic [NSLOT-1:0]  dirty,
    output logic [VER_W-1:0]  ver_ctr
);
    logic              vld_q   [NSLOT];
    logic              dirty_q [NSLOT];
    logic [TASK_W-1:0] tsk_q   [NSLOT];
    logic [VER_W-1:0]  ver_q   [NSLOT];
    logic [N-1:0]      dat_q   [NSLOT];
    logic [VER_W-1:0]  ctr_q;
    logic              wt_act_q;
    logic [SW-1:0]     wt_sel_q;
    logic              ack_hit, any_dirty;
    logic [SW-1:0]     low_dirty;

    assign ack_hit = wt_act_q && wt_ack;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        logic hit;
        assign hit = c_we && (c_slot == SW'(g));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q[g]   <= 1'b0;
                dirty_q[g] <= 1'b0;
                tsk_q[g]   <= '0;
                ver_q[g]   <= '0;
                dat_q[g]   <= '0;
            end else begin
                dirty_q[g] <= (dirty_q[g] && !(ack_hit && wt_sel_q == SW'(g))) || hit;
                if (hit) begin
                    vld_q[g] <= 1'b1;
                    tsk_q[g] <= c_task;
                    ver_q[g] <= ctr_q + 1'b1;
                    dat_q[g] <= c_data;
                end
            end
        end
        assign dirty[g] = dirty_q[g];
    end

    always_comb begin
        low_dirty = '0;
        any_dirty = 1'b0;
        for (int k = NSLOT - 1; k >= 0; k--) begin
            if (dirty_q[k]) begin
                low_dirty = SW'(k);
                any_dirty = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q    <= '0;
            wt_act_q <= 1'b0;
            wt_sel_q <= '0;
        end else begin
            if (c_we) ctr_q <= ctr_q + 1'b1;
            if (ack_hit) begin
                wt_act_q <= 1'b0;
            end else if (!wt_act_q && any_dirty) begin
                wt_act_q <= 1'b1;
                wt_sel_q <= low_dirty;
            end
        end
    end

    always_comb begin
        if (int'(lk_idx) < NSLOT) begin
            lk_valid = vld_q[lk_idx];
            lk_task  = tsk_q[lk_idx];
            lk_ver   = ver_q[lk_idx];
            lk_data  = dat_q[lk_idx];
        end else begin
            lk_valid = 1'b0;
            lk_task  = '0;
            lk_ver   = '0;
            lk_data  = '0;
        end
        wt_req  = wt_act_q;
        wt_slot = wt_sel_q;
        wt_task = tsk_q[wt_sel_q];
        wt_ver  = ver_q[wt_sel_q];
        wt_data = dat_q[wt_sel_q];
        ver_ctr = ctr_q;
    end

    // R3: each stamped save advances the counter by one
    p_stamp_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        c_we |=> (ctr_q == $past(ctr_q) + 1'b1));
    // R9: request held and slot kept until acknowledged
    p_wt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wt_act_q && !wt_ack) |=> (wt_act_q && $stable(wt_sel_q)));
    // R9: presented slot remains dirty while unacknowledged
    p_wt_dirty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wt_act_q && !wt_ack) |=> dirty_q[wt_sel_q]);
    // R11: commit on the acknowledged slot keeps something dirty
    p_collide_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_hit && c_we && c_slot == wt_sel_q) |=> (dirty != '0));
endmodule

// File: rtl/ctxv_fsm.sv
module ctxv_fsm
    import ctxv_pkg::*;
#(
    parameter int NSLOT  = 3,
    parameter int SW     = 2,
    parameter int TASK_W = 4,
    parameter int N      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [1:0]        cmd_op,
    input  logic [SW-1:0]     slot_idx,
    input  logic [TASK_W-1:0] task_id,
    input  logic [VER_W-1:0]  exp_ver,
    input  logic              lk_valid,
    input  logic [TASK_W-1:0] lk_task,
    input  logic [VER_W-1:0]  lk_ver,
    input  logic [N-1:0]      lk_data,
    input  logic              scan_in,
    output logic [SW-1:0]     lk_idx,
    output logic              scan_en,
    output logic              scan_out,
    output logic              c_we,
    output logic [SW-1:0]     c_slot,
    output logic [TASK_W-1:0] c_task,
    output logic [N-1:0]      c_data,
    output logic              busy,
    output logic              rej,
    output logic              err,
    output logic              done
);
    localparam int CW = $clog2(N);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    xfer_st_e          st_q, st_d;
    logic [CW-1:0]     cnt_q;
    logic [N-1:0]      shr_q;
    logic [SW-1:0]     cur_q;
    logic [TASK_W-1:0] ctask_q;
    logic              rej_q, err_q, done_q;
    logic              valid_op, go, bad_slot, load_ok, last;

    always_comb begin
        valid_op = (cmd_op == OP_SAVE) || (cmd_op == OP_LOAD);
        go       = cmd_wr && valid_op && (st_q == ST_IDLE);
        bad_slot = int'(slot_idx) >= NSLOT;
        load_ok  = !bad_slot && lk_valid && (lk_task == task_id) && (lk_ver == exp_ver);
        last     = (cnt_q == LAST);
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (go && cmd_op == OP_SAVE && !bad_slot)    st_d = ST_SAVE;
                else if (go && cmd_op == OP_LOAD && load_ok) st_d = ST_LOAD;
            end
            ST_SAVE: if (last) st_d = ST_IDLE;
            ST_LOAD: if (last) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shr_q   <= '0;
            cur_q   <= '0;
            ctask_q <= '0;
            rej_q   <= 1'b0;
            err_q   <= 1'b0;
            done_q  <= 1'b0;
        end else if (st_q != ST_IDLE) begin
            shr_q <= {scan_in, shr_q[N-1:1]};
            cnt_q <= last ? '0 : cnt_q + 1'b1;
            if (last) done_q <= 1'b1;
            if (cmd_wr && valid_op) rej_q <= 1'b1;
        end else if (go) begin
            rej_q   <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= bad_slot || (cmd_op == OP_LOAD && !load_ok);
            cnt_q   <= '0;
            cur_q   <= slot_idx;
            ctask_q <= task_id;
        end
    end

    always_comb begin
        busy     = (st_q != ST_IDLE);
        scan_en  = busy;
        scan_out = (st_q == ST_LOAD) ? lk_data[cnt_q] : 1'b0;
        lk_idx   = (st_q == ST_IDLE) ? slot_idx : cur_q;
        c_we     = (st_q == ST_SAVE) && last;
        c_slot   = cur_q;
        c_task   = ctask_q;
        c_data   = {scan_in, shr_q[N-1:1]};
        rej      = rej_q;
        err      = err_q;
        done     = done_q;
    end

    // R7: a transfer keeps its state until the last bit
    p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE && !last) |=> (st_q == $past(st_q)));
    // R7: the last bit always ends the transfer
    p_busy_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE && last) |=> (st_q == ST_IDLE));
    // R8: a command while busy raises the reject flag
    p_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && valid_op && st_q != ST_IDLE) |=> rej_q);
    // R6: a refused restore never starts shifting
    p_stale_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (go && cmd_op == OP_LOAD && !load_ok) |=> (!scan_en && err_q));
endmodule

// File: rtl/ctxv_unit.sv
module ctxv_unit
    import ctxv_pkg::*;
#(
    parameter int NSLOT  = 3,
    parameter int TASK_W = 4,
    parameter int N      = 16,
    localparam int SW    = $clog2(NSLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              scan_en,
    output logic              scan_out,
    input  logic              scan_in,
    output logic              wt_req,
    input  logic              wt_ack,
    output logic [SW-1:0]     wt_slot,
    output logic [TASK_W-1:0] wt_task,
    output logic [VER_W-1:0]  wt_ver,
    output logic [N-1:0]      wt_data
);
    logic [REG_W-1:0]  status;
    logic [SW-1:0]     slot_idx, lk_idx, c_slot;
    logic [TASK_W-1:0] task_id, lk_task, c_task;
    logic [VER_W-1:0]  exp_ver, lk_ver, ver_ctr;
    logic [N-1:0]      lk_data, c_data;
    logic [NSLOT-1:0]  dirty;
    logic [3:0]        dpad;
    logic              cmd_wr, lk_valid, c_we, busy, rej, err, done;
    logic [1:0]        cmd_op;

    ctxv_regs #(.SW(SW), .TASK_W(TASK_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .status(status), .reg_rdata(reg_rdata),
        .slot_idx(slot_idx), .task_id(task_id), .exp_ver(exp_ver),
        .cmd_wr(cmd_wr), .cmd_op(cmd_op)
    );

    ctxv_fsm #(.NSLOT(NSLOT), .SW(SW), .TASK_W(TASK_W), .N(N)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_op(cmd_op),
        .slot_idx(slot_idx), .task_id(task_id), .exp_ver(exp_ver),
        .lk_valid(lk_valid), .lk_task(lk_task), .lk_ver(lk_ver), .lk_data(lk_data),
        .scan_in(scan_in), .lk_idx(lk_idx), .scan_en(scan_en), .scan_out(scan_out),
        .c_we(c_we), .c_slot(c_slot), .c_task(c_task), .c_data(c_data),
        .busy(busy), .rej(rej), .err(err), .done(done)
    );

    ctxv_store #(.NSLOT(NSLOT), .SW(SW), .TASK_W(TASK_W), .N(N)) u_store (
        .clk(clk), .rst_n(rst_n), .c_we(c_we), .c_slot(c_slot), .c_task(c_task),
        .c_data(c_data), .lk_idx(lk_idx), .lk_valid(lk_valid), .lk_task(lk_task),
        .lk_ver(lk_ver), .lk_data(lk_data), .wt_ack(wt_ack), .wt_req(wt_req),
        .wt_slot(wt_slot), .wt_task(wt_task), .wt_ver(wt_ver), .wt_data(wt_data),
        .dirty(dirty), .ver_ctr(ver_ctr)
    );

    always_comb begin
        dpad = '0;
        dpad[NSLOT-1:0] = dirty;
        status = {ver_ctr, dpad, done, err, rej, busy};
    end

    // R9: the request does not drop without an acknowledge
    p_req_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wt_req && !wt_ack) |=> wt_req);
    // R6: a raised error flag never coincides with a new shift
    p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(err) && !$past(busy)) |-> !scan_en);
endmodule

// File: tb/ctxv_unit_test.sv
module ctxv_unit_test;
    localparam int N  = 16;
    localparam int NS = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        scan_en, scan_out, wt_req;
    logic        scan_in = 1'b0;
    logic        wt_ack = 1'b0;
    logic [1:0]  wt_slot;
    logic [3:0]  wt_task;
    logic [7:0]  wt_ver;
    logic [15:0] wt_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    ctxv_unit uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scan_en(scan_en),
        .scan_out(scan_out), .scan_in(scan_in), .wt_req(wt_req), .wt_ack(wt_ack),
        .wt_slot(wt_slot), .wt_task(wt_task), .wt_ver(wt_ver), .wt_data(wt_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int ms, mcnt, mcur, mtl, mctr, mwsel, mslot, mtsk, mexp;
    bit mv[NS], mdirty[NS], nd[NS];
    int mt[NS], mver[NS];
    logic [15:0] md[NS];
    logic [15:0] mshr, cd;
    bit mwact, mrej, merr, mdone, commit, ackhit, anyd, cmdw, bad, ok;
    int low;
    logic [1:0] op;

    function automatic logic [15:0] mstatus();
        return {mctr[7:0], 1'b0, mdirty[2], mdirty[1], mdirty[0], mdone, merr, mrej, ms != 0};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; mcnt = 0; mcur = 0; mtl = 0; mctr = 0; mwsel = 0;
            mslot = 0; mtsk = 0; mexp = 0; mshr = '0; mwact = 0;
            mrej = 0; merr = 0; mdone = 0;
            for (int k = 0; k < NS; k++) begin
                mv[k] = 0; mdirty[k] = 0; mt[k] = 0; mver[k] = 0; md[k] = '0;
            end
        end else begin
            commit = (ms == 1) && (mcnt == N - 1);
            cd = {scan_in, mshr[15:1]};
            ackhit = mwact && wt_ack;
            anyd = 0; low = 0;
            for (int k = NS - 1; k >= 0; k--) if (mdirty[k]) begin low = k; anyd = 1; end
            for (int k = 0; k < NS; k++)
                nd[k] = (mdirty[k] && !(ackhit && mwsel == k)) || (commit && mcur == k);
            if (ackhit) mwact = 0;
            else if (!mwact && anyd) begin mwact = 1; mwsel = low; end
            for (int k = 0; k < NS; k++) mdirty[k] = nd[k];
            if (commit) begin
                mctr = (mctr + 1) % 256;
                mv[mcur] = 1; mt[mcur] = mtl; mver[mcur] = mctr; md[mcur] = cd;
            end
            op = reg_wdata[1:0];
            cmdw = reg_we && reg_addr == 2'd0 && (op == 2'd1 || op == 2'd2);
            if (ms != 0) begin
                mshr = cd;
                if (mcnt == N - 1) begin ms = 0; mcnt = 0; mdone = 1; end
                else mcnt++;
                if (cmdw) mrej = 1;
            end else if (cmdw) begin
                mrej = 0; mdone = 0;
                bad = mslot >= NS;
                ok = !bad && mv[mslot] && mt[mslot] == mtsk && mver[mslot] == mexp;
                if (op == 2'd1) begin
                    merr = bad;
                    if (!bad) begin ms = 1; mcnt = 0; mcur = mslot; mtl = mtsk; end
                end else begin
                    merr = !ok;
                    if (ok) begin ms = 2; mcnt = 0; mcur = mslot; end
                end
            end
            if (reg_we) begin
                case (reg_addr)
                    2'd1: mslot = int'(reg_wdata[1:0]);
                    2'd2: mtsk = int'(reg_wdata[3:0]);
                    2'd3: mexp = int'(reg_wdata[7:0]);
                    default: ;
                endcase
            end
        end
    end

    // per-clock comparison, sampled 3 ns after the edge
    always @(posedge clk) begin
        #3;
        if (rst_n && !finished) begin
            chk("R7 scan_en model", scan_en, ms != 0);
            chk("R5 scan_out model", scan_out, (ms == 2) ? md[mcur][mcnt] : 1'b0);
            chk("R9 wt_req model", wt_req, mwact);
            if (mwact) begin
                chk("R10 wt_slot model", wt_slot, mwsel);
                chk("R9 wt_task model", wt_task, mt[mwsel]);
                chk("R3 wt_ver model", wt_ver, mver[mwsel]);
                chk("R4 wt_data model", wt_data, md[mwsel]);
            end
            case (reg_addr)
                2'd0: chk("R2 status model", reg_rdata, mstatus());
                2'd1: chk("R2 slot reg model", reg_rdata, mslot);
                2'd2: chk("R2 task reg model", reg_rdata, mtsk);
                default: chk("R2 expver reg model", reg_rdata, mexp);
            endcase
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = 16'd0;
    endtask

    task automatic do_save(input int slot, input int tsk, input logic [15:0] w,
                           input bit ack_last, input int poke);
        int en_cnt = 0;
        wr(2'd1, 16'(slot));
        wr(2'd2, 16'(tsk));
        wr(2'd0, 16'd1);
        for (int i = 0; i < N; i++) begin
            scan_in = w[i];
            if (scan_en) en_cnt++;
            if (ack_last && i == N - 1) wt_ack = 1'b1;
            if (i == poke) begin reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 16'd2; end
            if (i == poke + 1) begin reg_we = 1'b0; reg_wdata = 16'd0; end
            @(negedge clk);
        end
        wt_ack = 1'b0; scan_in = 1'b0; reg_we = 1'b0; reg_wdata = 16'd0;
        chk("R7 scan_en cycles per save", en_cnt, N);
        chk("R7 scan_en low after save", scan_en, 1'b0);
        chk("R7 done flag", reg_rdata[3], 1'b1);
    endtask

    task automatic do_load(input int slot, input int tsk, input int ev,
                           input bit expect_ok, input logic [15:0] w);
        wr(2'd1, 16'(slot));
        wr(2'd2, 16'(tsk));
        wr(2'd3, 16'(ev));
        wr(2'd0, 16'd2);
        if (expect_ok) begin
            chk("R13 error cleared at accepted restore", reg_rdata[2], 1'b0);
            for (int i = 0; i < N; i++) begin
                chk("R5 restored bit", scan_out, w[i]);
                @(negedge clk);
            end
            chk("R7 done after restore", reg_rdata[3], 1'b1);
        end else begin
            for (int i = 0; i < 3; i++) begin
                chk("R6 no shift on refused restore", scan_en, 1'b0);
                @(negedge clk);
            end
            chk("R6 error flag on refused restore", reg_rdata[2], 1'b1);
        end
    endtask

    task automatic ack_all();
        for (int i = 0; i < 20 && (wt_req || reg_rdata[6:4] != 3'b0); i++) begin
            wt_ack = wt_req;
            @(negedge clk);
            wt_ack = 1'b0;
        end
        chk("R9 all slots clean", reg_rdata[6:4], 3'b000);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 status after reset", reg_rdata, 16'h0000);
        chk("R1 no request after reset", wt_req, 1'b0);
        chk("R1 no shift after reset", scan_en, 1'b0);
        // R1 slots start invalid: restore of version 0 is refused
        do_load(0, 0, 0, 0, 16'h0);

        // R4 and R3: first save, no acknowledge yet
        do_save(0, 5, 16'hA5C3, 0, -1);
        @(negedge clk);
        chk("R9 request raised", wt_req, 1'b1);
        chk("R9 request slot", wt_slot, 2'd0);
        chk("R9 request task", wt_task, 4'd5);
        chk("R3 first version is 1", wt_ver, 8'd1);
        chk("R4 saved data", wt_data, 16'hA5C3);
        chk("R3 status version field", reg_rdata[15:8], 8'd1);
        repeat (3) @(negedge clk);
        chk("R9 request held", wt_req, 1'b1);
        chk("R9 dirty held", reg_rdata[4], 1'b1);
        wt_ack = 1'b1; @(negedge clk); wt_ack = 1'b0;
        chk("R9 request dropped after ack", wt_req, 1'b0);
        chk("R9 dirty cleared after ack", reg_rdata[4], 1'b0);

        // R5 matching restore, R6 stale version and wrong task
        do_load(0, 5, 1, 1, 16'hA5C3);
        do_load(0, 5, 2, 0, 16'h0);
        do_load(0, 6, 1, 0, 16'h0);

        // R8 command while busy is rejected
        do_save(1, 7, 16'h1234, 0, 4);
        chk("R8 reject flag", reg_rdata[1], 1'b1);
        chk("R8 only one stamp", reg_rdata[15:8], 8'd2);
        ack_all();
        // R8 command on the very last busy cycle
        do_save(1, 7, 16'h4321, 0, N - 1);
        chk("R8 reject on final cycle", reg_rdata[1], 1'b1);
        chk("R8 no restore started", scan_en, 1'b0);
        ack_all();

        // R10 arbitration and hold
        do_save(2, 3, 16'h0F0F, 0, -1);
        do_save(1, 4, 16'h00FF, 0, -1);
        chk("R10 presented slot kept", wt_slot, 2'd2);
        chk("R10 both dirty", reg_rdata[6:4], 3'b110);
        wt_ack = 1'b1; @(negedge clk); wt_ack = 1'b0;
        @(negedge clk);
        chk("R10 next slot presented", wt_slot, 2'd1);
        chk("R10 next version", wt_ver, 8'd5);
        ack_all();

        // R11 commit and acknowledge of the same slot on one edge
        do_save(0, 9, 16'h3C3C, 0, -1);
        @(negedge clk);
        chk("R11 first copy presented", wt_slot, 2'd0);
        do_save(0, 9, 16'hC3C3, 1, -1);
        chk("R11 dirty survives collision", reg_rdata[4], 1'b1);
        @(negedge clk);
        chk("R11 presented again", wt_req, 1'b1);
        chk("R11 new version", wt_ver, 8'd7);
        chk("R11 new data", wt_data, 16'hC3C3);
        ack_all();

        // R12 out of range slot
        wr(2'd1, 16'd3);
        wr(2'd0, 16'd1);
        chk("R12 error flag", reg_rdata[2], 1'b1);
        chk("R12 no shift", scan_en, 1'b0);
        chk("R12 no stamp", reg_rdata[15:8], 8'd7);

        // R2 ignored command codes keep the status
        wr(2'd0, 16'd0);
        wr(2'd0, 16'd3);
        chk("R2 ignored codes keep error", reg_rdata[3:0], 4'b0100);
        chk("R2 ignored codes no shift", scan_en, 1'b0);

        // R13 next evaluated command rewrites the flags
        do_load(0, 9, 7, 1, 16'hC3C3);
        chk("R13 reject cleared", reg_rdata[1], 1'b0);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule